// File: doc/BRIEF.md
# Competitive Snoop Update Counter

This block holds the per-line policy state for a hybrid update/invalidate snooping cache. Every line of the cache owns a small saturating down-counter. A line fill loads the counter with a threshold. A local read or write hit loads it again. Each bus update from another cache that hits the line counts it down. A sharer that keeps receiving remote updates without touching the line itself stops accepting them and drops its copy. Heavily shared data that is really in use then stays in update mode. Data that only one cache uses falls back to invalidate behaviour.

Two drop policies are selected by the plain `group_mode` pin. In per-line mode, a line is invalidated as soon as its own count reaches zero. In group mode, a line at zero stays Shared until the snooped update shows that every sharer is exhausted (`peers_zero`, the inverse of the wired-OR of all caches' `snp_keep`). On the writing side, when a local write to a Shared line sees no other sharer assert the shared line, the line moves to Modified and later writes need no bus update. All pins are plain control and status signals, one event of each kind per cycle. There is no streaming data path, so no valid/ready handshake applies.

Top module: `snoop_compete_ctr`

## Requirements
- R1: While `rst_n` is low and at the first sample after it, every line is Invalid (`line_valid` and `line_mod` all zero), `qry_cnt` reads 0, and `inv_pulse` and `mod_pulse` are low.
- R2: A fill of line i (`fill_vld`, `fill_idx`=i) makes the line Shared with count THRESH after the next clock edge.
- R3: A snooped update that hits a Shared line with count above 1 lowers the count by one and leaves the line Shared. A snooped update on an Invalid or Modified line changes neither its state nor its count.
- R4: A local read or write hit (`acc_vld`) on a Shared or Modified line reloads its count to THRESH. A local access to an Invalid line is ignored.
- R5: With `group_mode` low, a snooped update that brings a Shared line's count to zero makes the line Invalid. One cycle later `inv_pulse` is high for exactly one cycle, and `inv_idx` holds the line number.
- R6: With `group_mode` high, a snooped update that leaves the count at zero invalidates the line (with the R5 pulse) only if `peers_zero` is high in that cycle. Otherwise the line stays Shared, and the count saturates at zero.
- R7: A local write (`acc_wr`=1) to a Shared line with `shr_seen` low moves the line to Modified (`line_mod` bit set). `mod_pulse` and `mod_idx` then report it for one cycle after the edge. With `shr_seen` high, the line stays Shared. A write to a Modified line gives no pulse.
- R8: When several events name the same line in one cycle, fill beats local access, and local access beats snooped update. A fill or access together with a snoop leaves the count at THRESH.
- R9: `snp_keep` is combinational and high during a snooped update exactly when the target line is Shared and will still hold a nonzero count afterwards. That is the case when its count is above 1, or when a fill or local access hits the same line in the same cycle.
- R10: Events on one line leave every other line's state and count unchanged. `qry_cnt` shows the count of line `qry_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| group_mode | input | 1 | 0: per-line drop at zero, 1: drop only when all sharers are exhausted |
| fill_vld | input | 1 | Line fill this cycle |
| fill_idx | input | IDX_W | Line being filled |
| acc_vld | input | 1 | Local read or write hit this cycle |
| acc_wr | input | 1 | Local access is a write |
| acc_idx | input | IDX_W | Line of the local access |
| snp_vld | input | 1 | Snooped bus update hits a line this cycle |
| snp_idx | input | IDX_W | Line hit by the snooped update |
| shr_seen | input | 1 | Shared line sampled during this cache's own update |
| peers_zero | input | 1 | No sharer asserted keep during the snooped update |
| qry_idx | input | IDX_W | Line whose count is shown on qry_cnt |
| snp_keep | output | 1 | This cache still wants the snooped line |
| line_valid | output | LINES | Per-line valid (Shared or Modified) |
| line_mod | output | LINES | Per-line Modified |
| qry_cnt | output | CNT_W | Count of line qry_idx |
| inv_pulse | output | 1 | A line was dropped by the counter last cycle |
| inv_idx | output | IDX_W | Line dropped |
| mod_pulse | output | 1 | A line moved to Modified last cycle |
| mod_idx | output | IDX_W | Line that moved to Modified |

## Verification
The bench walks one line through a full countdown, with a local reload in the middle. A counter that does not reload, or that wraps past zero, would drop the line early or never. In group mode it holds a line at zero over repeated snoops, then releases it with `peers_zero`. A design that treated the variant like per-line mode would pulse too soon, and one that did not saturate would show 3 instead of 0. Same-cycle collisions of fill, access and snoop on one line show a wrong priority as a count of 2 instead of 3. The bench also probes `snp_keep` at counts 3 and 1 and checks that snoops on Invalid and Modified lines have no effect.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;
endpackage

// File: rtl/cs_event_dec.sv
// Turns an indexed event strobe into a one-hot per-line vector.
module cs_event_dec #(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             ev_vld,
  input  logic [IDX_W-1:0] ev_idx,
  output logic [LINES-1:0] ev_vec
);
  always_comb begin
    ev_vec = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ev_vld && (ev_idx == IDX_W'(i))) ev_vec[i] = 1'b1;
    end
  end
endmodule

// File: rtl/cs_line.sv
// One cache line: coherence state plus saturating competitive counter.
module cs_line
  import cs_pkg::*;
#(
  parameter int THRESH = 3,
  localparam int CNT_W = (THRESH > 0) ? $clog2(THRESH + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             group_mode,
  input  logic             fill,
  input  logic             acc,
  input  logic             acc_wr,
  input  logic             snp,
  input  logic             shr_seen,
  input  logic             peers_zero,
  output line_st_e         st,
  output logic [CNT_W-1:0] cnt,
  output logic             inv_ev,
  output logic             mod_ev,
  output logic             keep
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(THRESH);

  line_st_e         st_n;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] cnt_dec;
  logic             acc_hit;

  assign acc_hit = acc && (st != LN_INV);
  assign cnt_dec = (cnt == '0) ? '0 : cnt - CNT_W'(1);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    inv_ev = 1'b0;
    mod_ev = 1'b0;
    if (fill) begin
      st_n  = LN_SHR;
      cnt_n = FULL;
    end else if (acc_hit) begin
      cnt_n = FULL;
      if (acc_wr && (st == LN_SHR) && !shr_seen) begin
        st_n   = LN_MOD;
        mod_ev = 1'b1;
      end
    end else if (snp && (st == LN_SHR)) begin
      cnt_n = cnt_dec;
      if ((cnt_dec == '0) && (!group_mode || peers_zero)) begin
        st_n   = LN_INV;
        inv_ev = 1'b1;
      end
    end
  end

  assign keep = snp && (fill || (st == LN_SHR && (acc_hit || cnt > CNT_W'(1))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= LN_INV;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  p_fill_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (st == LN_SHR && cnt == FULL));
  p_snoop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp && !fill && !acc && st == LN_SHR && cnt > CNT_W'(1))
      |=> (st == LN_SHR && cnt == $past(cnt) - CNT_W'(1)));
  p_snoop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp && !fill && st != LN_SHR) |=> $stable(cnt));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !fill && st != LN_INV) |=> cnt == FULL);
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp && !fill && !acc && group_mode && !peers_zero && st == LN_SHR && cnt <= CNT_W'(1))
      |=> (st == LN_SHR && cnt == '0));
  p_to_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_wr && !fill && !shr_seen && st == LN_SHR) |=> st == LN_MOD);
endmodule

// File: rtl/cs_report.sv
// Registers the per-line drop and upgrade events into pulses with an index.
module cs_report #(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] inv_vec,
  input  logic [LINES-1:0] mod_vec,
  output logic             inv_pulse,
  output logic [IDX_W-1:0] inv_idx,
  output logic             mod_pulse,
  output logic [IDX_W-1:0] mod_idx
);
  logic [IDX_W-1:0] inv_enc;
  logic [IDX_W-1:0] mod_enc;

  always_comb begin
    inv_enc = '0;
    mod_enc = '0;
    for (int i = 0; i < LINES; i++) begin
      if (inv_vec[i]) inv_enc = IDX_W'(i);
      if (mod_vec[i]) mod_enc = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_pulse <= 1'b0;
      inv_idx   <= '0;
      mod_pulse <= 1'b0;
      mod_idx   <= '0;
    end else begin
      inv_pulse <= |inv_vec;
      inv_idx   <= inv_enc;
      mod_pulse <= |mod_vec;
      mod_idx   <= mod_enc;
    end
  end

  p_one_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inv_vec));
  p_one_upgrade_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_vec));
endmodule

// File: rtl/snoop_compete_ctr.sv
module snoop_compete_ctr
  import cs_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int THRESH = 3,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CNT_W = (THRESH > 0) ? $clog2(THRESH + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             group_mode,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             snp_vld,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             shr_seen,
  input  logic             peers_zero,
  input  logic [IDX_W-1:0] qry_idx,
  output logic             snp_keep,
  output logic [LINES-1:0] line_valid,
  output logic [LINES-1:0] line_mod,
  output logic [CNT_W-1:0] qry_cnt,
  output logic             inv_pulse,
  output logic [IDX_W-1:0] inv_idx,
  output logic             mod_pulse,
  output logic [IDX_W-1:0] mod_idx
);
  logic [LINES-1:0] fill_vec, acc_vec, snp_vec;
  logic [LINES-1:0] inv_vec, mod_vec, keep_vec;
  logic [CNT_W-1:0] cnt_arr [LINES];
  line_st_e         st_arr  [LINES];

  cs_event_dec #(.LINES(LINES)) u_dec_fill (.ev_vld(fill_vld), .ev_idx(fill_idx), .ev_vec(fill_vec));
  cs_event_dec #(.LINES(LINES)) u_dec_acc  (.ev_vld(acc_vld),  .ev_idx(acc_idx),  .ev_vec(acc_vec));
  cs_event_dec #(.LINES(LINES)) u_dec_snp  (.ev_vld(snp_vld),  .ev_idx(snp_idx),  .ev_vec(snp_vec));

  for (genvar g = 0; g < LINES; g++) begin : g_line
    cs_line #(.THRESH(THRESH)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .group_mode (group_mode),
      .fill       (fill_vec[g]),
      .acc        (acc_vec[g]),
      .acc_wr     (acc_wr),
      .snp        (snp_vec[g]),
      .shr_seen   (shr_seen),
      .peers_zero (peers_zero),
      .st         (st_arr[g]),
      .cnt        (cnt_arr[g]),
      .inv_ev     (inv_vec[g]),
      .mod_ev     (mod_vec[g]),
      .keep       (keep_vec[g])
    );
    assign line_valid[g] = (st_arr[g] != LN_INV);
    assign line_mod[g]   = (st_arr[g] == LN_MOD);
  end

  assign snp_keep = |keep_vec;
  assign qry_cnt  = cnt_arr[qry_idx];

  cs_report #(.LINES(LINES)) u_report (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_vec   (inv_vec),
    .mod_vec   (mod_vec),
    .inv_pulse (inv_pulse),
    .inv_idx   (inv_idx),
    .mod_pulse (mod_pulse),
    .mod_idx   (mod_idx)
  );

  p_drop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |-> !line_valid[inv_idx]);
  p_upgrade_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_pulse |-> line_mod[mod_idx]);
  p_keep_needs_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_keep |-> snp_vld);
endmodule

// File: tb/snoop_compete_ctr_tb_top.sv
`timescale 1ns/1ps
module snoop_compete_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       group_mode = 1'b0;
  logic       fill_vld = 1'b0;
  logic [2:0] fill_idx = '0;
  logic       acc_vld = 1'b0;
  logic       acc_wr = 1'b0;
  logic [2:0] acc_idx = '0;
  logic       snp_vld = 1'b0;
  logic [2:0] snp_idx = '0;
  logic       shr_seen = 1'b0;
  logic       peers_zero = 1'b0;
  logic [2:0] qry_idx = '0;
  logic       snp_keep;
  logic [7:0] line_valid, line_mod;
  logic [1:0] qry_cnt;
  logic       inv_pulse, mod_pulse;
  logic [2:0] inv_idx, mod_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  snoop_compete_ctr #(.LINES(8), .THRESH(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .group_mode(group_mode),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_idx(acc_idx),
    .snp_vld(snp_vld), .snp_idx(snp_idx),
    .shr_seen(shr_seen), .peers_zero(peers_zero), .qry_idx(qry_idx),
    .snp_keep(snp_keep), .line_valid(line_valid), .line_mod(line_mod),
    .qry_cnt(qry_cnt), .inv_pulse(inv_pulse), .inv_idx(inv_idx),
    .mod_pulse(mod_pulse), .mod_idx(mod_idx)
  );

  typedef struct packed {
    logic       m;  logic f; logic [2:0] fi;
    logic       a;  logic w; logic [2:0] ai;
    logic       s;  logic [2:0] si;
    logic       sh; logic az; logic [2:0] q;
    logic [7:0] ev; logic [7:0] em; logic [1:0] ec;
    logic       ei; logic [2:0] eii; logic emo; logic [2:0] emi;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 28;
  // m f fi a w ai s si sh az q | valid mod cnt inv idx mod idx | req
  localparam vec_t TAB [NV] = '{
    '{0,1,2,0,0,0,0,0,0,0,2, 8'h04,8'h00,3, 0,0,0,0, 2},  // R2 fill
    '{0,0,0,0,0,0,1,2,0,0,2, 8'h04,8'h00,2, 0,0,0,0, 3},  // R3 dec
    '{0,0,0,0,0,0,1,2,0,0,2, 8'h04,8'h00,1, 0,0,0,0, 3},
    '{0,0,0,1,0,2,0,0,0,0,2, 8'h04,8'h00,3, 0,0,0,0, 4},  // R4 reload
    '{0,0,0,0,0,0,1,2,0,0,2, 8'h04,8'h00,2, 0,0,0,0, 3},
    '{0,0,0,0,0,0,1,2,0,0,2, 8'h04,8'h00,1, 0,0,0,0, 3},
    '{0,0,0,0,0,0,1,2,0,0,2, 8'h00,8'h00,0, 1,2,0,0, 5},  // R5 drop
    '{0,0,0,0,0,0,1,2,0,0,2, 8'h00,8'h00,0, 0,0,0,0, 3},  // R3 snoop invalid
    '{0,0,0,1,0,2,0,0,0,0,2, 8'h00,8'h00,0, 0,0,0,0, 4},  // R4 access invalid
    '{0,1,5,0,0,0,0,0,0,0,5, 8'h20,8'h00,3, 0,0,0,0, 2},
    '{0,0,0,1,1,5,0,0,1,0,5, 8'h20,8'h00,3, 0,0,0,0, 7},  // R7 shared seen
    '{0,0,0,1,1,5,0,0,0,0,5, 8'h20,8'h20,3, 0,0,1,5, 7},  // R7 upgrade
    '{0,0,0,0,0,0,1,5,0,0,5, 8'h20,8'h20,3, 0,0,0,0, 3},  // R3 snoop modified
    '{1,1,1,0,0,0,0,0,0,0,1, 8'h22,8'h20,3, 0,0,0,0, 2},
    '{1,0,0,0,0,0,1,1,0,0,1, 8'h22,8'h20,2, 0,0,0,0, 6},
    '{1,0,0,0,0,0,1,1,0,0,1, 8'h22,8'h20,1, 0,0,0,0, 6},
    '{1,0,0,0,0,0,1,1,0,0,1, 8'h22,8'h20,0, 0,0,0,0, 6},  // R6 zero, kept
    '{1,0,0,0,0,0,1,1,0,0,1, 8'h22,8'h20,0, 0,0,0,0, 6},  // R6 saturate
    '{1,0,0,0,0,0,1,1,0,1,1, 8'h20,8'h20,0, 1,1,0,0, 6},  // R6 release
    '{0,1,3,0,0,0,0,0,0,0,3, 8'h28,8'h20,3, 0,0,0,0, 2},
    '{0,0,0,0,0,0,1,3,0,0,3, 8'h28,8'h20,2, 0,0,0,0, 3},
    '{0,1,3,0,0,0,1,3,0,0,3, 8'h28,8'h20,3, 0,0,0,0, 8},  // R8 fill beats snoop
    '{0,0,0,0,0,0,1,3,0,0,3, 8'h28,8'h20,2, 0,0,0,0, 3},
    '{0,0,0,1,0,3,1,3,0,0,3, 8'h28,8'h20,3, 0,0,0,0, 8},  // R8 access beats snoop
    '{0,1,0,0,0,0,1,3,0,0,0, 8'h29,8'h20,3, 0,0,0,0, 10}, // R10 two lines
    '{0,0,0,0,0,0,0,0,0,0,3, 8'h29,8'h20,2, 0,0,0,0, 10},
    '{1,0,0,0,0,0,1,3,0,1,3, 8'h29,8'h20,1, 0,0,0,0, 6},
    '{1,0,0,0,0,0,1,3,0,1,3, 8'h21,8'h20,0, 1,3,0,0, 6}   // R6 release on reaching zero
  };

  task automatic idle();
    fill_vld = 0; acc_vld = 0; acc_wr = 0; snp_vld = 0;
    shr_seen = 0; peers_zero = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(line_valid == 0 && line_mod == 0 && qry_cnt == 0 && !inv_pulse && !mod_pulse,
        "R1", "reset state", {line_valid, line_mod}, 0);

    for (int i = 0; i < NV; i++) begin
      group_mode = TAB[i].m;
      fill_vld = TAB[i].f; fill_idx = TAB[i].fi;
      acc_vld = TAB[i].a; acc_wr = TAB[i].w; acc_idx = TAB[i].ai;
      snp_vld = TAB[i].s; snp_idx = TAB[i].si;
      shr_seen = TAB[i].sh; peers_zero = TAB[i].az;
      qry_idx = TAB[i].q;
      @(posedge clk);
      @(negedge clk);
      idle();
      checks++;
      if (line_valid != TAB[i].ev || line_mod != TAB[i].em || qry_cnt != TAB[i].ec ||
          inv_pulse != TAB[i].ei || (TAB[i].ei && inv_idx != TAB[i].eii) ||
          mod_pulse != TAB[i].emo || (TAB[i].emo && mod_idx != TAB[i].emi)) begin
        failures++;
        $display("FAIL R%0d row %0d actual v=%h m=%h c=%0d i=%b/%0d u=%b/%0d expected v=%h m=%h c=%0d i=%b/%0d u=%b/%0d",
                 TAB[i].rq, i, line_valid, line_mod, qry_cnt, inv_pulse, inv_idx, mod_pulse, mod_idx,
                 TAB[i].ev, TAB[i].em, TAB[i].ec, TAB[i].ei, TAB[i].eii, TAB[i].emo, TAB[i].emi);
      end
    end

    // R5 pulse lasts one cycle only
    @(posedge clk); @(negedge clk);
    chk(!inv_pulse && !mod_pulse, "R5", "pulses clear when idle", {inv_pulse, mod_pulse}, 0);

    // R9 keep probes on line 4 (count 3 after fill)
    group_mode = 0; fill_vld = 1; fill_idx = 4;
    @(posedge clk); @(negedge clk); idle();
    snp_vld = 1; snp_idx = 4; #1;
    chk(snp_keep == 1'b1, "R9", "keep at count 3", snp_keep, 1);
    @(posedge clk); @(negedge clk);
    snp_vld = 1; snp_idx = 4;
    @(posedge clk); @(negedge clk);
    snp_vld = 1; snp_idx = 4; #1;
    chk(snp_keep == 1'b0, "R9", "keep at count 1", snp_keep, 0);
    acc_vld = 1; acc_idx = 4; #1;
    chk(snp_keep == 1'b1, "R9", "keep with same-cycle access", snp_keep, 1);
    idle(); snp_vld = 1; snp_idx = 6; #1;
    chk(snp_keep == 1'b0, "R9", "keep on invalid line", snp_keep, 0);
    idle(); qry_idx = 4;
    @(posedge clk); @(negedge clk);
    chk(qry_cnt == 2'd1 && line_valid[4], "R10", "line 4 untouched by line 6 snoop", qry_cnt, 1);

    // R7 write on a Modified line gives no new pulse
    acc_vld = 1; acc_wr = 1; acc_idx = 5;
    @(posedge clk); @(negedge clk); idle();
    chk(!mod_pulse && line_mod[5], "R7", "write to modified line", mod_pulse, 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    qry_idx = 5; #1;
    chk(line_valid == 0 && line_mod == 0 && qry_cnt == 0 && !inv_pulse && !mod_pulse,
        "R1", "reset after activity", {line_valid, line_mod}, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule